// File: doc/BRIEF.md
# Burst Address Sequencer for Paged Byte Memory

This block produces the address sequence of one burst into a memory organised as rows of 2^COL_W bytes (1024 by default). A burst is started by a load strobe that captures a start address (row in the upper bits, column in the lower bits), a window-length code, a hybrid-wrap flag, a linear-command flag, a read/write flag and a row-crossing enable. After that, every accepted advance moves the burst on by one double-data-rate beat, which is two bytes. The block presents the even and odd byte addresses of the current beat together with a valid flag.

Three ordering schemes are supported. Plain wrap keeps the column inside an aligned window of 16, 32, 64 or full-page bytes. Hybrid wrap makes one wrapped pass through the small window, jumps to the window's upper edge, runs on to the page end and then wraps over the whole page. A linear command ignores the length and hybrid settings and wraps over the whole page. If row crossing is enabled, a linear read that reaches the last beat of a row goes on to column 0 of the next row (the last row goes on to row 0). Before that happens, a wait of WAIT_CYC clock cycles passes with valid low and the address held.

Top module: `burst_addr_seq`

## Requirements
- R1: One cycle after `load_i`, `valid_o` is 1 and the address is the start address with column bit 0 forced to 0. `load_i` takes priority over every other activity, including a pending row-cross wait.
- R2: While `valid_o` is 1 and `advance_i` is 0, the address does not change. Out of reset, `valid_o` is 0, `cross_wait_o` is 0, and the address is 0.
- R3: With hybrid off and the linear command off, length code 0/1/2/3 selects a wrap window of 16/32/64/page bytes. Each advance adds 2 to the column modulo the window, and the column bits above the window stay fixed. Example: start 4 with code 0 gives 4, 6, …, 14, 0, 2.
- R4: With hybrid on and code 0–2, the column first wraps within the window. When the next column would equal the start column again, the column jumps to the window base plus the window size instead. From there it steps by 2 modulo the page size. Example: start 2 with code 0 gives 2…14, 0, 16, 18, …, 1022, 0, 2.
- R5: With hybrid on and code 3, the sequence is the same as plain full-page wrap.
- R6: With the linear command on, the length code and the hybrid flag are ignored and the column steps by 2 modulo the page size.
- R7: For a linear read with row crossing enabled, advancing from column page-2 (3FEh) leads to row+1 and column 0. The row number wraps from the last row to row 0.
- R8: A row crossing holds the old address and drives `valid_o` low and `cross_wait_o` high for exactly WAIT_CYC cycles. After that, the new address appears with `valid_o` high. Advances during the wait are ignored.
- R9: A write, and any read that is not a linear read with crossing enabled, never changes the row. At the page end the column wraps to 0 in the same row.
- R10: `addr_hi_o` always equals `addr_lo_o` with bit 0 set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| load_i | input | 1 | Start a new burst from the inputs below |
| start_addr_i | input | ROW_W+COL_W | Start address, row above column |
| len_code_i | input | 2 | Window length code: 0=16, 1=32, 2=64, 3=page |
| hybrid_i | input | 1 | Hybrid wrap ordering |
| linear_i | input | 1 | Linear command, overrides length and hybrid |
| read_i | input | 1 | 1 = read burst, 0 = write burst |
| cross_en_i | input | 1 | Allow linear reads to continue into the next row |
| advance_i | input | 1 | Step one beat (two bytes) when valid |
| addr_lo_o | output | ROW_W+COL_W | Even byte address of the current beat |
| addr_hi_o | output | ROW_W+COL_W | Odd byte address of the current beat |
| valid_o | output | 1 | Current beat address is usable |
| cross_wait_o | output | 1 | Row-crossing wait in progress |

## Verification
The hardest situations to reach are the later parts of a hybrid burst and the row crossing. The hybrid burst only reaches its page-end wrap after hundreds of advances. The row crossing only fires on the exact beat at 3FEh, and only for a linear read with crossing enabled. The directed cases start bursts a few beats below the page end and on the last row, so both happen quickly. They also load a new burst in the middle of a wait. The random bursts choose start columns near the page end for part of the time and run long advance runs with gaps, so all the mode combinations reach their boundaries.

// File: rtl/burst_pkg.sv
package burst_pkg;

   // width of the window for each length code; code 3 means the full page
   function automatic int unsigned win_bytes(input logic [1:0] code, input int unsigned col_w);
      case (code)
         2'd0:    win_bytes = 16;
         2'd1:    win_bytes = 32;
         2'd2:    win_bytes = 64;
         default: win_bytes = 1 << col_w;
      endcase
   endfunction

   typedef struct packed {
      logic [1:0] len;
      logic       hyb;
      logic       lin;
      logic       rd;
      logic       xen;
   } burst_mode_t;

endpackage

// File: rtl/burst_col_step.sv
module burst_col_step #(
   parameter int COL_W = 10
) (
   input  logic [COL_W-1:0] col_i,
   input  logic [COL_W-1:0] first_i,
   input  logic [1:0]       len_i,
   input  logic             hyb_i,
   input  logic             lin_i,
   input  logic             done_i,
   output logic [COL_W-1:0] nxt_o,
   output logic             set_done_o,
   output logic             page_end_o
);
   localparam logic [COL_W-1:0] PAGE_LAST = '1;

   logic [COL_W-1:0] mask_tab [4];
   logic [COL_W-1:0] mask, base, inc, wrapn, jump;
   logic             full;

   for (genvar k = 0; k < 4; k++) begin : g_mask
      if (k == 3) begin : g_page
         assign mask_tab[k] = '1;
      end else begin : g_win
         assign mask_tab[k] = COL_W'((16 << k) - 1);
      end
   end

   assign full  = lin_i | (len_i == 2'd3);
   assign mask  = full ? '1 : mask_tab[len_i];
   assign base  = col_i & ~mask;
   assign inc   = col_i + COL_W'(2);
   assign wrapn = base | (inc & mask);
   assign jump  = base + mask + COL_W'(1);

   always_comb begin
      set_done_o = 1'b0;
      if (full || (hyb_i && done_i)) begin
         nxt_o = inc;
      end else if (hyb_i && (wrapn == first_i)) begin
         nxt_o      = jump;
         set_done_o = 1'b1;
      end else begin
         nxt_o = wrapn;
      end
   end

   assign page_end_o = (col_i == (PAGE_LAST - COL_W'(1)));
endmodule

// File: rtl/burst_cross_wait.sv
module burst_cross_wait #(
   parameter int WAIT_CYC = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clear_i,
   input  logic start_i,
   output logic busy_o,
   output logic done_o
);
   localparam int CW = $clog2(WAIT_CYC + 1);

   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)               cnt_q <= '0;
      else if (clear_i)         cnt_q <= '0;
      else if (start_i)         cnt_q <= CW'(WAIT_CYC);
      else if (cnt_q != '0)     cnt_q <= cnt_q - CW'(1);
   end

   assign busy_o = (cnt_q != '0);
   assign done_o = (cnt_q == CW'(1));

   assert_wait_len_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (start_i && !clear_i) |=> (cnt_q == CW'(WAIT_CYC)));
endmodule

// File: rtl/burst_addr_seq.sv
module burst_addr_seq #(
   parameter int ROW_W    = 13,
   parameter int COL_W    = 10,
   parameter int WAIT_CYC = 4
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   load_i,
   input  logic [ROW_W+COL_W-1:0] start_addr_i,
   input  logic [1:0]             len_code_i,
   input  logic                   hybrid_i,
   input  logic                   linear_i,
   input  logic                   read_i,
   input  logic                   cross_en_i,
   input  logic                   advance_i,
   output logic [ROW_W+COL_W-1:0] addr_lo_o,
   output logic [ROW_W+COL_W-1:0] addr_hi_o,
   output logic                   valid_o,
   output logic                   cross_wait_o
);
   import burst_pkg::*;

   localparam int ADDR_W = ROW_W + COL_W;

   if (COL_W < 7)    begin : g_bad_col  $error("COL_W must hold a 64-byte window"); end
   if (ROW_W < 1)    begin : g_bad_row  $error("ROW_W must be at least 1"); end
   if (WAIT_CYC < 1) begin : g_bad_wait $error("WAIT_CYC must be at least 1"); end

   logic [ROW_W-1:0] row_q;
   logic [COL_W-1:0] col_q, first_q, nxt_col;
   logic             done_q, valid_q, set_done, page_end;
   burst_mode_t      mode_q;
   logic             cross_req, wbusy, wdone, step;

   burst_col_step #(.COL_W(COL_W)) u_step (
      .col_i      (col_q),
      .first_i    (first_q),
      .len_i      (mode_q.len),
      .hyb_i      (mode_q.hyb),
      .lin_i      (mode_q.lin),
      .done_i     (done_q),
      .nxt_o      (nxt_col),
      .set_done_o (set_done),
      .page_end_o (page_end)
   );

   assign step      = valid_q & advance_i & ~load_i;
   assign cross_req = step & page_end & mode_q.lin & mode_q.rd & mode_q.xen;

   burst_cross_wait #(.WAIT_CYC(WAIT_CYC)) u_wait (
      .clk     (clk),
      .rst_n   (rst_n),
      .clear_i (load_i),
      .start_i (cross_req),
      .busy_o  (wbusy),
      .done_o  (wdone)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         row_q   <= '0;
         col_q   <= '0;
         first_q <= '0;
         done_q  <= 1'b0;
         valid_q <= 1'b0;
         mode_q  <= '0;
      end else if (load_i) begin
         row_q   <= start_addr_i[ADDR_W-1:COL_W];
         col_q   <= {start_addr_i[COL_W-1:1], 1'b0};
         first_q <= {start_addr_i[COL_W-1:1], 1'b0};
         done_q  <= 1'b0;
         valid_q <= 1'b1;
         mode_q  <= '{len: len_code_i, hyb: hybrid_i, lin: linear_i,
                      rd: read_i, xen: cross_en_i};
      end else if (wdone) begin
         row_q   <= row_q + ROW_W'(1);
         col_q   <= '0;
         valid_q <= 1'b1;
      end else if (cross_req) begin
         valid_q <= 1'b0;
      end else if (step) begin
         col_q  <= nxt_col;
         done_q <= done_q | set_done;
      end
   end

   assign addr_lo_o    = {row_q, col_q};
   assign addr_hi_o    = {row_q, col_q[COL_W-1:1], 1'b1};
   assign valid_o      = valid_q;
   assign cross_wait_o = wbusy;

   assert_load_R1: assert property (@(posedge clk) disable iff (!rst_n)
      load_i |=> (valid_o && addr_lo_o == {$past(start_addr_i[ADDR_W-1:1]), 1'b0}));

   assert_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (valid_o && !advance_i && !load_i) |=> ($stable(addr_lo_o) && valid_o));

   assert_window_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (step && !mode_q.lin && !mode_q.hyb && mode_q.len != 2'd3) |=>
      ((col_q >> $clog2(win_bytes(mode_q.len, COL_W))) ==
       ($past(col_q) >> $clog2(win_bytes(mode_q.len, COL_W)))));

   assert_cross_target_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (wdone && !load_i) |=> (valid_o && col_q == '0 && row_q == $past(row_q) + ROW_W'(1)));

   assert_wait_invalid_R8: assert property (@(posedge clk) disable iff (!rst_n)
      wbusy |-> !valid_o);

   assert_write_row_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (!mode_q.rd && !load_i) |=> $stable(row_q));
endmodule

// File: tb/burst_addr_seq_tb.sv
`timescale 1ns/1ps
module burst_addr_seq_tb;
   localparam int ROW_W = 13;
   localparam int COL_W = 10;
   localparam int WC    = 4;
   localparam int AW    = ROW_W + COL_W;
   localparam int PAGE  = 1 << COL_W;
   localparam int NROW  = 1 << ROW_W;

   logic clk = 0;
   logic rst_n = 0;
   logic load = 0, hyb = 0, lin = 0, rd = 0, xen = 0, adv = 0;
   logic [1:0] len = 0;
   logic [AW-1:0] saddr = 0;
   logic [AW-1:0] a_lo, a_hi;
   logic v, w;

   int errors = 0, checks = 0;
   bit fin = 0;
   string tag = "R2";

   // reference state
   int m_row = 0, m_col = 0, m_first = 0, m_wait = 0;
   bit m_done = 0, m_valid = 0;
   bit q_hyb, q_lin, q_rd, q_xen;
   int q_len;

   always #2.5 clk = ~clk;

   burst_addr_seq #(.ROW_W(ROW_W), .COL_W(COL_W), .WAIT_CYC(WC)) u_dut (
      .clk(clk), .rst_n(rst_n), .load_i(load), .start_addr_i(saddr),
      .len_code_i(len), .hybrid_i(hyb), .linear_i(lin), .read_i(rd),
      .cross_en_i(xen), .advance_i(adv), .addr_lo_o(a_lo), .addr_hi_o(a_hi),
      .valid_o(v), .cross_wait_o(w));

   function automatic int wsize(int code);
      return (code == 3) ? PAGE : (16 << code);
   endfunction

   task automatic model_step();
      if (load) begin
         m_row = int'(saddr[AW-1:COL_W]);
         m_col = int'(saddr[COL_W-1:0]) & ~1;
         m_first = m_col; m_done = 0; m_valid = 1; m_wait = 0;
         q_len = int'(len); q_hyb = hyb; q_lin = lin; q_rd = rd; q_xen = xen;
      end else if (m_wait > 0) begin
         if (m_wait == 1) begin
            m_row = (m_row + 1) % NROW; m_col = 0; m_valid = 1;
         end
         m_wait--;
      end else if (m_valid && adv) begin
         if (q_lin && q_rd && q_xen && m_col == PAGE - 2) begin
            m_wait = WC; m_valid = 0;
         end else if (q_lin || q_len == 3 || (q_hyb && m_done)) begin
            m_col = (m_col + 2) % PAGE;
         end else begin
            int ws = wsize(q_len);
            int base = m_col - (m_col % ws);
            int n = base + ((m_col + 2 - base) % ws);
            if (q_hyb && n == m_first) begin
               n = (base + ws) % PAGE; m_done = 1;
            end
            m_col = n;
         end
      end
   endtask

   task automatic tick();
      @(posedge clk);
      model_step();
      #1;
      checks++;
      begin
         logic [AW-1:0] elo = AW'(m_row * PAGE + m_col);
         logic [AW-1:0] ehi = elo | AW'(1);
         if (a_lo !== elo || a_hi !== ehi || v !== m_valid || w !== (m_wait > 0)) begin
            errors++;
            $display("FAIL %s: lo=%h hi=%h v=%b w=%b expected lo=%h hi=%h v=%b w=%b",
                     tag, a_lo, a_hi, v, w, elo, ehi, m_valid, (m_wait > 0));
         end
      end
   endtask

   task automatic start(int row, int col, int code, bit h, bit l, bit r, bit x);
      saddr = AW'(row * PAGE + col); len = 2'(code);
      hyb = h; lin = l; rd = r; xen = x; load = 1; adv = 0;
      tick();
      load = 0;
   endtask

   task automatic run(int n);
      adv = 1;
      for (int i = 0; i < n; i++) tick();
      adv = 0;
   endtask

   initial begin
      repeat (195000) @(posedge clk);
      if (!fin) begin
         errors++; checks++;
         $display("FAIL R2: watchdog expired, actual=hung expected=finished");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd7121));
      repeat (3) @(posedge clk);
      #1;
      // R2 reset state
      tag = "R2"; checks++;
      if (v !== 1'b0 || w !== 1'b0 || a_lo !== '0) begin
         errors++;
         $display("FAIL R2: reset v=%b w=%b lo=%h expected 0 0 0", v, w, a_lo);
      end
      rst_n = 1;
      tick();
      // R1 load with odd column forced even; R2 advance before load ignored
      tag = "R1"; start(7, 5, 0, 0, 0, 1, 0);
      tag = "R2"; tick(); tick();
      // R3 plain 16-byte wrap from 4
      tag = "R3"; start(3, 4, 0, 0, 0, 1, 0); run(12);
      start(3, 40, 1, 0, 0, 0, 0); run(20);
      start(3, 100, 2, 0, 0, 1, 0); run(40);
      // R4 hybrid 16 from 2 through page end
      tag = "R4"; start(9, 2, 0, 1, 0, 1, 0); run(520);
      start(9, 14, 0, 1, 0, 0, 0); run(30);
      start(9, 1000, 2, 1, 0, 1, 0); run(60);
      // R5 hybrid code 3
      tag = "R5"; start(2, 1016, 3, 1, 0, 1, 0); run(10);
      // R6 linear ignores len and hybrid
      tag = "R6"; start(4, 1010, 0, 1, 1, 1, 0); run(12);
      // R7 crossing, mid row and last row
      tag = "R7"; start(5, 1016, 1, 0, 1, 1, 1); run(12);
      start(NROW - 1, 1018, 0, 0, 1, 1, 1); run(10);
      // R8 load during a wait
      tag = "R8"; start(6, 1020, 0, 0, 1, 1, 1); run(3);
      start(11, 30, 0, 0, 0, 1, 0); run(3);
      // R9 write with crossing enabled stays in row
      tag = "R9"; start(8, 1016, 0, 0, 1, 0, 1); run(10);
      tag = "R9"; start(8, 1016, 0, 0, 1, 1, 0); run(10);
      // R10 covered on every compare; random mix
      tag = "R10";
      for (int b = 0; b < 200; b++) begin
         int col = ($urandom % 2) ? int'($urandom % PAGE) : PAGE - 2 * int'($urandom % 40);
         int steps = int'($urandom % 500) + 1;
         start(int'($urandom % NROW), col % PAGE, int'($urandom % 4), bit'($urandom % 2),
               bit'($urandom % 2), bit'($urandom % 2), bit'($urandom % 2));
         for (int s = 0; s < steps; s++) begin
            adv = (($urandom % 5) != 0);
            tick();
         end
         adv = 0;
      end
      fin = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule